// File: doc/BRIEF.md
# Slot-Scheduled Shared Word Memory Arbiter

This block shares one single-port memory of 32-bit words among four clients: a filter stage that writes samples, a monitor that reads them, a signal-processing core, and an 8-bit host processor. The arbiter avoids contention without any request-based priority. A free-running four-cycle schedule gives the filter, the monitor and the host one fixed cycle each, in that order. The processing core gets the fourth cycle. A client that has nothing to do in its cycle leaves that cycle unused. Each client learns the current slot from the `slot_id` output and presents its request during its own slot. Read data appears on the shared `rd_data` bus in the following cycle, together with that client's valid flag.

The 8-bit host reaches the 32-bit words through a byte bridge built around a four-state machine. The states are IDLE, WCOMMIT (a full word waits for the host slot), RFETCH (a read waits for the host slot) and RRET (fetched data returns). The transitions are named as follows:
- IDLE goes to WCOMMIT on a write of the top byte.
- IDLE goes to RFETCH on a read of byte 0.
- WCOMMIT goes to IDLE in the host slot, when the word is committed.
- RFETCH goes to RRET in the host slot, when the memory read is issued.
- RRET always goes to IDLE.

Every other host byte access completes in IDLE at once. The host holds its request while `mpu_wait` is high and drops it in the cycle where `mpu_wait` is low.

Top module: `slot_mem_arbiter`

## Requirements
- R1: `slot_id` is 0 in the first cycle after reset release and counts 0,1,2,3,0,... with one step per clock. Slot 0 belongs to the filter, 1 to the monitor, 2 to the host, and 3 to the processing core.
- R2: When `fir_req` is high during slot 0, `fir_wdata` is written to word `fir_addr`.
- R3: When `mon_req` is high during slot 1, the next cycle has `mon_rvalid` high and `rd_data` equal to word `mon_addr`.
- R4: When `dsp_req` is high during slot 3, the core accesses word `dsp_addr`. With `dsp_we` high it writes `dsp_wdata`. With `dsp_we` low, the next cycle has `dsp_rvalid` high and `rd_data` carrying the word.
- R5: A filter, monitor or core request raised outside its own slot has no effect: nothing is written and no valid flag is raised.
- R6: Host writes to lanes 0 to 2 (`mpu_we`=1) complete with `mpu_wait` low in the same cycle and are held in a holding register.
- R7: A host write to lane 3 raises `mpu_wait` until the first slot-2 cycle strictly after the request cycle. In that cycle the word {lane3,lane2,lane1,lane0} is written to `mpu_addr`, with lane k in bits 8k+7:8k.
- R8: A host read of lane 0 raises `mpu_wait` while the bridge waits for the first slot-2 cycle strictly after the request. The word is fetched in that slot. In the cycle after it, `mpu_wait` falls and `mpu_rdata` shows bits 7:0.
- R9: Host reads of lanes 1 to 3 complete with `mpu_wait` low in the same cycle. They return bits 8k+7:8k of the word last fetched by a lane-0 read.
- R10: After reset, `mon_rvalid`, `dsp_rvalid` and `mpu_wait` are low. `mpu_wait` is only ever high while `mpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_id | output | 2 | Current schedule slot |
| fir_req | input | 1 | Filter write request |
| fir_addr | input | 6 | Filter word address |
| fir_wdata | input | 32 | Filter write word |
| mon_req | input | 1 | Monitor read request |
| mon_addr | input | 6 | Monitor word address |
| mon_rvalid | output | 1 | Monitor read data valid on rd_data |
| dsp_req | input | 1 | Core access request |
| dsp_we | input | 1 | Core write (1) or read (0) |
| dsp_addr | input | 6 | Core word address |
| dsp_wdata | input | 32 | Core write word |
| dsp_rvalid | output | 1 | Core read data valid on rd_data |
| rd_data | output | 32 | Shared read data bus |
| mpu_req | input | 1 | Host byte access request |
| mpu_we | input | 1 | Host write (1) or read (0) |
| mpu_lane | input | 2 | Byte lane within the word |
| mpu_addr | input | 6 | Host word address |
| mpu_wdata | input | 8 | Host write byte |
| mpu_rdata | output | 8 | Host read byte |
| mpu_wait | output | 1 | Host must hold its request |

## Verification
The hardest cases to reach from the ports are the pending host commit and the pending host fetch, because their wait length depends on the slot phase in which the host raised its request. The worst phase is a request raised in slot 2 itself, which must wait a full round. The bench issues the top-byte write and the byte-0 read once in each of the four phases. It predicts the wait length arithmetically from the phase and checks `mpu_wait` cycle by cycle. It then reads the committed word back through the monitor to confirm the byte order.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    typedef enum logic [1:0] {
        SLOT_FIR = 2'd0,
        SLOT_MON = 2'd1,
        SLOT_MPU = 2'd2,
        SLOT_DSP = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        HB_IDLE    = 2'd0,
        HB_WCOMMIT = 2'd1,
        HB_RFETCH  = 2'd2,
        HB_RRET    = 2'd3
    } hb_state_e;

endpackage

// File: rtl/slot_sched.sv
module slot_sched
    import slot_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    logic [1:0] slot_nxt;

    assign slot_nxt = slot + 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_FIR;
        else        slot <= slot_e'(slot_nxt);
    end

    // R1: one step per clock, wrapping after the core slot
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (slot == slot_e'($past(slot) + 2'd1)));

endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/mpu_bridge.sv
module mpu_bridge
    import slot_arb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HOST_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [$clog2(WORD_W/HOST_W)-1:0] host_lane,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [HOST_W-1:0] host_rdata,
    output logic              br_we,
    output logic              br_re,
    output logic [ADDR_W-1:0] br_addr,
    output logic [WORD_W-1:0] br_wdata,
    input  logic [WORD_W-1:0] mem_q
);

    localparam int LANES  = WORD_W / HOST_W;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    hb_state_e state, state_nxt;
    logic [LANES-1:0][HOST_W-1:0] whold;
    logic [LANES-1:0][HOST_W-1:0] rhold;
    logic [ADDR_W-1:0] addr_q;
    logic lat_w, lat_r, lat_a;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HB_IDLE;
        else        state <= state_nxt;
    end

    // Next state and outputs
    always_comb begin
        state_nxt  = state;
        host_ack   = 1'b0;
        host_rdata = '0;
        br_we      = 1'b0;
        br_re      = 1'b0;
        lat_w      = 1'b0;
        lat_r      = 1'b0;
        lat_a      = 1'b0;
        unique case (state)
            HB_IDLE: begin
                if (host_req) begin
                    if (host_we) begin
                        lat_w = 1'b1;
                        if (host_lane == LAST_LANE) begin
                            lat_a     = 1'b1;
                            state_nxt = HB_WCOMMIT;
                        end else begin
                            host_ack = 1'b1;
                        end
                    end else if (host_lane == '0) begin
                        lat_a     = 1'b1;
                        state_nxt = HB_RFETCH;
                    end else begin
                        host_ack   = 1'b1;
                        host_rdata = rhold[host_lane];
                    end
                end
            end
            HB_WCOMMIT: begin
                if (slot == SLOT_MPU) begin
                    br_we     = 1'b1;
                    host_ack  = 1'b1;
                    state_nxt = HB_IDLE;
                end
            end
            HB_RFETCH: begin
                if (slot == SLOT_MPU) begin
                    br_re     = 1'b1;
                    state_nxt = HB_RRET;
                end
            end
            HB_RRET: begin
                host_ack   = 1'b1;
                host_rdata = mem_q[HOST_W-1:0];
                lat_r      = 1'b1;
                state_nxt  = HB_IDLE;
            end
        endcase
    end

    // Holding registers
    always_ff @(posedge clk) begin
        if (lat_w) whold[host_lane] <= host_wdata;
        if (lat_a) addr_q <= host_addr;
        if (lat_r) rhold <= mem_q;
    end

    assign br_addr  = addr_q;
    assign br_wdata = whold;

    // R8: a fetch issued in the host slot returns in the very next cycle
    a_r8_fetch_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HB_RFETCH && slot == SLOT_MPU) |=> host_ack);

    // R7: a pending commit stays pending outside the host slot
    a_r7_commit_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HB_WCOMMIT && slot != SLOT_MPU) |-> !host_ack);

    // R10: bridge state is idle in the first cycle after reset
    a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> state == HB_IDLE);

endmodule

// File: rtl/slot_mem_arbiter.sv
module slot_mem_arbiter
    import slot_arb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HOST_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [1:0]        slot_id,
    input  logic              fir_req,
    input  logic [ADDR_W-1:0] fir_addr,
    input  logic [WORD_W-1:0] fir_wdata,
    input  logic              mon_req,
    input  logic [ADDR_W-1:0] mon_addr,
    output logic              mon_rvalid,
    input  logic              dsp_req,
    input  logic              dsp_we,
    input  logic [ADDR_W-1:0] dsp_addr,
    input  logic [WORD_W-1:0] dsp_wdata,
    output logic              dsp_rvalid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              mpu_req,
    input  logic              mpu_we,
    input  logic [$clog2(WORD_W/HOST_W)-1:0] mpu_lane,
    input  logic [ADDR_W-1:0] mpu_addr,
    input  logic [HOST_W-1:0] mpu_wdata,
    output logic [HOST_W-1:0] mpu_rdata,
    output logic              mpu_wait
);

    slot_e slot;
    logic ram_we, ram_re;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_wdata, ram_q;
    logic br_we, br_re, mpu_ack;
    logic [ADDR_W-1:0] br_addr;
    logic [WORD_W-1:0] br_wdata;

    slot_sched u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    mpu_bridge #(.WORD_W(WORD_W), .HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .host_req   (mpu_req),
        .host_we    (mpu_we),
        .host_lane  (mpu_lane),
        .host_addr  (mpu_addr),
        .host_wdata (mpu_wdata),
        .host_ack   (mpu_ack),
        .host_rdata (mpu_rdata),
        .br_we      (br_we),
        .br_re      (br_re),
        .br_addr    (br_addr),
        .br_wdata   (br_wdata),
        .mem_q      (ram_q)
    );

    sample_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    // Slot-owned port mux
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (slot)
            SLOT_FIR: begin
                ram_we    = fir_req;
                ram_addr  = fir_addr;
                ram_wdata = fir_wdata;
            end
            SLOT_MON: begin
                ram_re   = mon_req;
                ram_addr = mon_addr;
            end
            SLOT_MPU: begin
                ram_we    = br_we;
                ram_re    = br_re;
                ram_addr  = br_addr;
                ram_wdata = br_wdata;
            end
            SLOT_DSP: begin
                ram_we    = dsp_req & dsp_we;
                ram_re    = dsp_req & ~dsp_we;
                ram_addr  = dsp_addr;
                ram_wdata = dsp_wdata;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_rvalid <= 1'b0;
            dsp_rvalid <= 1'b0;
        end else begin
            mon_rvalid <= (slot == SLOT_MON) & mon_req;
            dsp_rvalid <= (slot == SLOT_DSP) & dsp_req & ~dsp_we;
        end
    end

    assign slot_id  = slot;
    assign rd_data  = ram_q;
    assign mpu_wait = mpu_req & ~mpu_ack;

    // R3: monitor data valid only right after a monitor slot
    a_r3_mon_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mon_rvalid |-> $past(slot) == SLOT_MON);

    // R4: core data valid only right after a core slot
    a_r4_dsp_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_rvalid |-> $past(slot) == SLOT_DSP);

    // R5: the monitor slot never writes the memory
    a_r5_no_write_mon_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && slot == SLOT_MON));

    // R7: a host-slot write is the cycle the host is released
    a_r7_commit_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && slot == SLOT_MPU && mpu_req) |-> !mpu_wait);

    // R10: wait only while the host requests
    a_r10_wait_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mpu_wait |-> mpu_req);

endmodule

// File: tb/sim_slot_mem_arbiter.sv
`timescale 1ns/1ps
module sim_slot_mem_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  slot_id;
    logic        fir_req = 0, mon_req = 0, dsp_req = 0, dsp_we = 0;
    logic [5:0]  fir_addr = 0, mon_addr = 0, dsp_addr = 0, mpu_addr = 0;
    logic [31:0] fir_wdata = 0, dsp_wdata = 0, rd_data;
    logic        mon_rvalid, dsp_rvalid, mpu_wait;
    logic        mpu_req = 0, mpu_we = 0;
    logic [1:0]  mpu_lane = 0;
    logic [7:0]  mpu_wdata = 0, mpu_rdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    slot_mem_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
        .fir_req(fir_req), .fir_addr(fir_addr), .fir_wdata(fir_wdata),
        .mon_req(mon_req), .mon_addr(mon_addr), .mon_rvalid(mon_rvalid),
        .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rvalid(dsp_rvalid), .rd_data(rd_data),
        .mpu_req(mpu_req), .mpu_we(mpu_we), .mpu_lane(mpu_lane),
        .mpu_addr(mpu_addr), .mpu_wdata(mpu_wdata), .mpu_rdata(mpu_rdata),
        .mpu_wait(mpu_wait)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 50000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", wd);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_slot(input int s);
        while ((cyc % 4) != s) tick();
    endtask

    function automatic logic [31:0] fword(input int a);
        return (32'h0102_0409 * (a + 1)) ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [31:0] hword(input int p);
        return (32'h1357_9BDF * (p + 3)) ^ 32'hF00D_0000;
    endfunction

    task automatic mon_read(input int a, input logic [31:0] exp, input string tag);
        wait_slot(1);
        mon_addr = a[5:0];
        mon_req  = 1'b1;
        tick();
        mon_req = 1'b0;
        #1;
        chk(mon_rvalid == 1'b1, {tag, " rvalid"}, {31'd0, mon_rvalid}, 32'd1);
        chk(rd_data == exp, {tag, " data"}, rd_data, exp);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R10 / R1 reset state
        chk(slot_id == 2'd0, "R1 first slot", {30'd0, slot_id}, 32'd0);
        chk(mon_rvalid == 0 && dsp_rvalid == 0, "R10 valids low", {30'd0, mon_rvalid, dsp_rvalid}, 32'd0);
        chk(mpu_wait == 0, "R10 wait low", {31'd0, mpu_wait}, 32'd0);

        // R1 schedule order
        for (int i = 0; i < 8; i++) begin
            #1;
            chk(slot_id == 2'(cyc % 4), "R1 slot order", {30'd0, slot_id}, cyc % 4);
            tick();
        end

        // R2 filter writes, R3 monitor reads
        for (int a = 0; a < 16; a++) begin
            wait_slot(0);
            fir_addr  = a[5:0];
            fir_wdata = fword(a);
            fir_req   = 1'b1;
            tick();
            fir_req = 1'b0;
        end
        for (int a = 0; a < 16; a++) mon_read(a, fword(a), "R2 R3 fir/mon word");

        // R5 out-of-slot filter write ignored
        wait_slot(3);
        fir_addr = 6'd5; fir_wdata = 32'hDEAD_BEEF; fir_req = 1'b1;
        tick();
        fir_req = 1'b0;
        mon_read(5, fword(5), "R5 fir outside slot");
        // R5 out-of-slot monitor request raises no valid
        wait_slot(2);
        mon_addr = 6'd1; mon_req = 1'b1;
        tick();
        mon_req = 1'b0;
        #1;
        chk(mon_rvalid == 1'b0, "R5 mon outside slot", {31'd0, mon_rvalid}, 32'd0);
        // R5 out-of-slot core write ignored
        wait_slot(0);
        dsp_addr = 6'd6; dsp_wdata = 32'h0BAD_F00D; dsp_we = 1'b1; dsp_req = 1'b1;
        tick();
        dsp_req = 1'b0; dsp_we = 1'b0;
        mon_read(6, fword(6), "R5 dsp outside slot");

        // R4 core write then read
        for (int a = 16; a < 24; a++) begin
            wait_slot(3);
            dsp_addr = a[5:0]; dsp_wdata = ~fword(a); dsp_we = 1'b1; dsp_req = 1'b1;
            tick();
            dsp_req = 1'b0; dsp_we = 1'b0;
        end
        for (int a = 16; a < 24; a++) begin
            wait_slot(3);
            dsp_addr = a[5:0]; dsp_req = 1'b1;
            tick();
            dsp_req = 1'b0;
            #1;
            chk(dsp_rvalid == 1'b1, "R4 dsp rvalid", {31'd0, dsp_rvalid}, 32'd1);
            chk(rd_data == ~fword(a), "R4 dsp data", rd_data, ~fword(a));
            chk(mon_rvalid == 1'b0, "R4 mon flag stays low", {31'd0, mon_rvalid}, 32'd0);
        end

        // R6 R7 R8 R9 host sweep over the four request phases
        for (int p = 0; p < 4; p++) begin
            logic [31:0] w;
            int d;
            w = hword(p);
            d = (2 - p + 4) % 4;
            if (d == 0) d = 4;
            mpu_addr = 6'(32 + p);
            for (int k = 0; k < 3; k++) begin
                mpu_we = 1'b1; mpu_lane = 2'(k); mpu_wdata = w[8*k +: 8]; mpu_req = 1'b1;
                #1;
                chk(mpu_wait == 1'b0, "R6 low lane write no wait", {31'd0, mpu_wait}, 32'd0);
                tick();
            end
            mpu_req = 1'b0;
            wait_slot(p);
            mpu_we = 1'b1; mpu_lane = 2'd3; mpu_wdata = w[31:24]; mpu_req = 1'b1;
            for (int i = 0; i <= d; i++) begin
                #1;
                chk(mpu_wait == (i != d), "R7 commit wait timing", {31'd0, mpu_wait}, {31'd0, i != d});
                if (i < d) tick();
            end
            mpu_req = 1'b0;
            tick();
            mon_read(32 + p, w, "R7 committed word order");

            wait_slot(p);
            mpu_we = 1'b0; mpu_lane = 2'd0; mpu_req = 1'b1;
            for (int i = 0; i <= d + 1; i++) begin
                #1;
                chk(mpu_wait == (i != d + 1), "R8 fetch wait timing", {31'd0, mpu_wait}, {31'd0, i != d + 1});
                if (i < d + 1) tick();
            end
            chk(mpu_rdata == w[7:0], "R8 byte0 data", {24'd0, mpu_rdata}, {24'd0, w[7:0]});
            mpu_req = 1'b0;
            tick();
            for (int k = 1; k < 4; k++) begin
                mpu_we = 1'b0; mpu_lane = 2'(k); mpu_req = 1'b1;
                #1;
                chk(mpu_wait == 1'b0, "R9 held byte no wait", {31'd0, mpu_wait}, 32'd0);
                chk(mpu_rdata == w[8*k +: 8], "R9 held byte data", {24'd0, mpu_rdata}, {24'd0, w[8*k +: 8]});
                tick();
            end
            mpu_req = 1'b0;
            #1;
            chk(mpu_wait == 1'b0, "R10 wait drops with req", {31'd0, mpu_wait}, 32'd0);
        end

        summary();
        $finish;
    end

endmodule